// File: doc/BRIEF.md
# Blanking Cycle Spreader

This unit takes the count of idle blanking grayscale-clock cycles that remain at the end of a display frame and turns it into two timing fields. Spreading the time this way avoids one long dark gap in the frame. First the unit divides the blank count by the number of segments in the frame, which is the sub-period count times the scan-line count. The quotient is added to the base segment length, so every segment gets longer by the same amount. The remainder from that division is then divided by the sub-period count. That quotient becomes an extra adjustment applied once per sub-period. Whatever is still left is reported as a leftover count.

A controller places the blank count, the sub-period count, the scan-line count and the base segment length on the inputs and pulses `start` for one cycle. A single restoring divider, 17 bits wide, produces one quotient bit per clock. It is shared by both stages, so a calculation takes at most about forty cycles. When both stages are complete, `done` is high for exactly one cycle. The results stay on the outputs until the next calculation completes.

While a calculation is running, `start` is ignored. A new `start` is accepted in the same cycle that `done` is high.

Top module: `blank_spread_calc`

## Requirements
- R1: Stage one runs only if the blank count is strictly greater than sub_cnt × line_cnt. When it runs, the per-segment addition is blank_cnt / (sub_cnt × line_cnt) using integer division, and the remainder goes on to stage two. When it does not run, the addition is 0 and the whole blank count goes on to stage two.
- R2: `seg_len` equals `base_len` plus the stage-one addition.
- R3: Stage two runs only if the amount carried from stage one is strictly greater than `sub_cnt`. When it runs, `sub_adj` is the integer quotient of that amount divided by `sub_cnt`, and `leftover` is the remainder. When it does not run, `sub_adj` is 0 and `leftover` is the carried amount.
- R4: If the segment sum is greater than 1023, `seg_len` saturates at 1023 and `overflow` is 1.
- R5: If the stage-two quotient is greater than 63, `sub_adj` saturates at 63 and `overflow` is 1. Otherwise `overflow` is 0, unless R4 applies.
- R6: `cfg_word` carries `seg_len` in bits 9..0 and `sub_adj` in bits 46..41. All other bits of `cfg_word` are 0.
- R7: If `sub_cnt` or `line_cnt` is zero, the result is `seg_len` = `base_len`, `sub_adj` = 0, `leftover` = `blank_cnt` and `overflow` = 0.
- R8: Each accepted start produces exactly one `done` pulse, one cycle long. The outputs hold their values from that pulse until the next result.
- R9: A `start` that arrives while a calculation is in progress is ignored and produces no result. A `start` that arrives in the cycle `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a calculation |
| blank_cnt | input | 17 | Number of idle blanking cycles |
| sub_cnt | input | 7 | Number of sub-periods |
| line_cnt | input | 7 | Number of scan lines |
| base_len | input | 10 | Base segment length |
| done | output | 1 | One-cycle pulse when results are valid |
| seg_len | output | 10 | Lengthened segment, saturated |
| sub_adj | output | 6 | Adjustment per sub-period, saturated |
| leftover | output | 17 | Count remaining after stage two |
| overflow | output | 1 | A field saturated |
| cfg_word | output | 48 | Both fields packed into a configuration word |

## Verification
Two events can fall in the same cycle: delivery of one result and acceptance of the next `start`. The bench drives `start` at exactly the moment `done` is high. The scoreboard must then receive both results, each one correct and in order, with no result lost and none extra. The bench also pulses `start` in the middle of a division, using different operands. Here the scoreboard must see only the single expected result.

// File: rtl/blank_spread_pkg.sv
package blank_spread_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV1,
    ST_CHK2,
    ST_DIV2,
    ST_OUT
  } calc_state_t;
endpackage

// File: rtl/bsc_divider.sv
module bsc_divider #(
  parameter int DW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] quotient,
  output logic [DW-1:0] remainder
);
  localparam int CW = $clog2(DW + 1);

  logic [DW:0]   acc;
  logic [DW-1:0] quo;
  logic [DW-1:0] dvs_q;
  logic [CW-1:0] cnt;
  logic [DW:0]   shifted;
  logic [DW:0]   diff;

  always_comb begin
    shifted = {acc[DW-1:0], quo[DW-1]};
    diff    = shifted - {1'b0, dvs_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      quo   <= '0;
      dvs_q <= '0;
      cnt   <= '0;
      done  <= 1'b0;
    end else if (go) begin
      acc   <= '0;
      quo   <= dividend;
      dvs_q <= divisor;
      cnt   <= CW'(DW);
      done  <= 1'b0;
    end else if (cnt != '0) begin
      if (!diff[DW]) begin
        acc <= diff;
        quo <= {quo[DW-2:0], 1'b1};
      end else begin
        acc <= shifted;
        quo <= {quo[DW-2:0], 1'b0};
      end
      cnt  <= cnt - 1'b1;
      done <= (cnt == CW'(1));
    end else begin
      done <= 1'b0;
    end
  end

  assign busy      = (cnt != '0);
  assign quotient  = quo;
  assign remainder = acc[DW-1:0];

  // R3: a finished division leaves a remainder below its divisor
  assert_rem_below_divisor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (remainder < dvs_q));
endmodule

// File: rtl/bsc_pack.sv
module bsc_pack #(
  parameter int DW      = 17,
  parameter int SEG_W   = 10,
  parameter int ADJ_W   = 6,
  parameter int CFG_W   = 48,
  parameter int SEG_LSB = 0,
  parameter int ADJ_LSB = 41
) (
  input  logic [SEG_W-1:0] base,
  input  logic [DW-1:0]    seg_add,
  input  logic [DW-1:0]    sub_add,
  output logic [SEG_W-1:0] seg,
  output logic [ADJ_W-1:0] adj,
  output logic             ovf,
  output logic [CFG_W-1:0] cfg
);
  localparam logic [DW:0]   SEG_LIM = (DW+1)'((1 << SEG_W) - 1);
  localparam logic [DW-1:0] ADJ_LIM = DW'((1 << ADJ_W) - 1);

  logic [DW:0] sum;
  logic        seg_sat;
  logic        adj_sat;

  always_comb begin
    sum     = {{(DW + 1 - SEG_W){1'b0}}, base} + {1'b0, seg_add};
    seg_sat = (sum > SEG_LIM);
    adj_sat = (sub_add > ADJ_LIM);
    seg     = seg_sat ? {SEG_W{1'b1}} : sum[SEG_W-1:0];
    adj     = adj_sat ? {ADJ_W{1'b1}} : sub_add[ADJ_W-1:0];
    ovf     = seg_sat | adj_sat;
    cfg     = '0;
    cfg[SEG_LSB +: SEG_W] = seg;
    cfg[ADJ_LSB +: ADJ_W] = adj;
  end
endmodule

// File: rtl/blank_spread_calc.sv
module blank_spread_calc
  import blank_spread_pkg::*;
#(
  parameter int BLANK_W = 17,
  parameter int SUB_W   = 7,
  parameter int LINE_W  = 7,
  parameter int SEG_W   = 10,
  parameter int ADJ_W   = 6,
  parameter int CFG_W   = 48,
  parameter int SEG_LSB = 0,
  parameter int ADJ_LSB = 41
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [BLANK_W-1:0] blank_cnt,
  input  logic [SUB_W-1:0]   sub_cnt,
  input  logic [LINE_W-1:0]  line_cnt,
  input  logic [SEG_W-1:0]   base_len,
  output logic               done,
  output logic [SEG_W-1:0]   seg_len,
  output logic [ADJ_W-1:0]   sub_adj,
  output logic [BLANK_W-1:0] leftover,
  output logic               overflow,
  output logic [CFG_W-1:0]   cfg_word
);
  localparam int PROD_W = SUB_W + LINE_W;

  calc_state_t        state;
  logic [SEG_W-1:0]   base_q;
  logic [SUB_W-1:0]   sub_q;
  logic [BLANK_W-1:0] q1_q, r1_q, q2_q, r2_q;

  logic [PROD_W-1:0]  prod;
  logic [BLANK_W-1:0] prod_ext, sub_ext;
  logic               cfg_bad;
  logic               div_go, div_busy, div_done;
  logic [BLANK_W-1:0] div_a, div_b, div_q, div_r;
  logic [SEG_W-1:0]   pk_seg;
  logic [ADJ_W-1:0]   pk_adj;
  logic               pk_ovf;
  logic [CFG_W-1:0]   pk_cfg;

  always_comb begin
    prod     = PROD_W'(sub_cnt) * PROD_W'(line_cnt);
    prod_ext = {{(BLANK_W - PROD_W){1'b0}}, prod};
    sub_ext  = {{(BLANK_W - SUB_W){1'b0}}, sub_q};
    cfg_bad  = (sub_cnt == '0) || (line_cnt == '0);
    div_go   = 1'b0;
    div_a    = blank_cnt;
    div_b    = prod_ext;
    if (state == ST_IDLE) begin
      div_go = start && !cfg_bad && (blank_cnt > prod_ext);
    end else if (state == ST_CHK2) begin
      div_a  = r1_q;
      div_b  = sub_ext;
      div_go = (r1_q > sub_ext);
    end
  end

  bsc_divider #(.DW(BLANK_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (div_go),
    .dividend  (div_a),
    .divisor   (div_b),
    .busy      (div_busy),
    .done      (div_done),
    .quotient  (div_q),
    .remainder (div_r)
  );

  bsc_pack #(
    .DW(BLANK_W), .SEG_W(SEG_W), .ADJ_W(ADJ_W),
    .CFG_W(CFG_W), .SEG_LSB(SEG_LSB), .ADJ_LSB(ADJ_LSB)
  ) u_pack (
    .base    (base_q),
    .seg_add (q1_q),
    .sub_add (q2_q),
    .seg     (pk_seg),
    .adj     (pk_adj),
    .ovf     (pk_ovf),
    .cfg     (pk_cfg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      base_q   <= '0;
      sub_q    <= '0;
      q1_q     <= '0;
      r1_q     <= '0;
      q2_q     <= '0;
      r2_q     <= '0;
      done     <= 1'b0;
      seg_len  <= '0;
      sub_adj  <= '0;
      leftover <= '0;
      overflow <= 1'b0;
      cfg_word <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          base_q <= base_len;
          sub_q  <= sub_cnt;
          q1_q   <= '0;
          r1_q   <= blank_cnt;
          if (cfg_bad) begin
            q2_q  <= '0;
            r2_q  <= blank_cnt;
            state <= ST_OUT;
          end else if (div_go) begin
            state <= ST_DIV1;
          end else begin
            state <= ST_CHK2;
          end
        end
        ST_DIV1: if (div_done) begin
          q1_q  <= div_q;
          r1_q  <= div_r;
          state <= ST_CHK2;
        end
        ST_CHK2: if (div_go) begin
          state <= ST_DIV2;
        end else begin
          q2_q  <= '0;
          r2_q  <= r1_q;
          state <= ST_OUT;
        end
        ST_DIV2: if (div_done) begin
          q2_q  <= div_q;
          r2_q  <= div_r;
          state <= ST_OUT;
        end
        ST_OUT: begin
          seg_len  <= pk_seg;
          sub_adj  <= pk_adj;
          leftover <= r2_q;
          overflow <= pk_ovf;
          cfg_word <= pk_cfg;
          done     <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: the completion pulse lasts a single cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: results hold while a calculation is under way
  assert_hold_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && state != ST_OUT) |=> ($stable(seg_len) && $stable(leftover)));

  // R2: without saturation the segment never shrinks below its base
  assert_seg_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !overflow) |-> (seg_len >= base_q));

  // R9: the divider is idle whenever a new request can be accepted
  assert_idle_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !div_busy);
endmodule

// File: tb/blank_spread_calc_tb.sv
module blank_spread_calc_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [9:0]  seg;
    logic [5:0]  adj;
    logic [16:0] left;
    logic        ovf;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [16:0] blank_cnt = '0;
  logic [6:0]  sub_cnt = '0;
  logic [6:0]  line_cnt = '0;
  logic [9:0]  base_len = '0;
  logic        done;
  logic [9:0]  seg_len;
  logic [5:0]  sub_adj;
  logic [16:0] leftover;
  logic        overflow;
  logic [47:0] cfg_word;

  int checks = 0;
  int errors = 0;
  exp_t  exp_q[$];
  string tag_q[$];
  logic  prev_done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blank_spread_calc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .blank_cnt(blank_cnt),
    .sub_cnt(sub_cnt), .line_cnt(line_cnt), .base_len(base_len),
    .done(done), .seg_len(seg_len), .sub_adj(sub_adj), .leftover(leftover),
    .overflow(overflow), .cfg_word(cfg_word)
  );

  function automatic exp_t model(int b, int s, int l, int base);
    exp_t e;
    int prod, q1, r1, q2, r2, sum;
    if (s == 0 || l == 0) begin
      e.seg = 10'(base); e.adj = '0; e.left = 17'(b); e.ovf = 1'b0;
      return e;
    end
    prod = s * l;
    q1 = (b > prod) ? b / prod : 0;
    r1 = (b > prod) ? b % prod : b;
    q2 = (r1 > s) ? r1 / s : 0;
    r2 = (r1 > s) ? r1 % s : r1;
    sum = base + q1;
    e.ovf = 1'b0;
    if (sum > 1023) begin e.seg = 10'd1023; e.ovf = 1'b1; end
    else e.seg = 10'(sum);
    if (q2 > 63) begin e.adj = 6'd63; e.ovf = 1'b1; end
    else e.adj = 6'(q2);
    e.left = 17'(r2);
    return e;
  endfunction

  task automatic check(input bit ok, input string what, input string act, input string expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %s expected %s", what, act, expv);
    end
  endtask

  // monitor: pops expected results as the design delivers them
  always @(negedge clk) begin
    if (rst_n) begin
      check(!(done && prev_done), "R8 done width", "2+ cycles", "1 cycle");
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected result", "extra done", "none");
        end else begin
          exp_t e;
          string t;
          logic [47:0] c;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          c = '0; c[9:0] = e.seg; c[46:41] = e.adj;
          check(seg_len == e.seg, {t, " R2/R4 seg_len"}, $sformatf("%0d", seg_len), $sformatf("%0d", e.seg));
          check(sub_adj == e.adj, {t, " R3/R5 sub_adj"}, $sformatf("%0d", sub_adj), $sformatf("%0d", e.adj));
          check(leftover == e.left, {t, " R3 leftover"}, $sformatf("%0d", leftover), $sformatf("%0d", e.left));
          check(overflow == e.ovf, {t, " R4/R5 overflow"}, $sformatf("%0d", overflow), $sformatf("%0d", e.ovf));
          check(cfg_word == c, {t, " R6 cfg_word"}, $sformatf("%h", cfg_word), $sformatf("%h", c));
        end
      end
    end
    prev_done = done;
  end

  task automatic drive(input int b, input int s, input int l, input int base, input string tag);
    blank_cnt = 17'(b); sub_cnt = 7'(s); line_cnt = 7'(l); base_len = 10'(base);
    start = 1'b1;
    exp_q.push_back(model(b, s, l, base));
    tag_q.push_back(tag);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_case(input int b, input int s, input int l, input int base, input string tag);
    @(negedge clk);
    drive(b, s, l, base, tag);
    drain();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [9:0] held;
    repeat (3) @(negedge clk);
    check(done == 0 && seg_len == 0 && leftover == 0 && overflow == 0 && cfg_word == 0,
          "R8 reset state", $sformatf("%0d/%0d", done, seg_len), "0/0");
    rst_n = 1'b1;
    @(negedge clk);

    run_case(86100, 32, 30, 512, "R1 worked case");          // 601, 20, 20
    run_case(900, 32, 30, 512, "R1 below threshold");
    run_case(960, 32, 30, 100, "R1 equal threshold");
    run_case(5, 5, 3, 7, "R3 carried equals sub");
    run_case(4000, 3, 7, 300, "R3 both stages");
    run_case(100000, 2, 2, 1000, "R4 seg saturation");
    run_case(99, 1, 100, 10, "R5 adj saturation");
    run_case(1234, 0, 30, 77, "R7 zero sub");
    run_case(1234, 8, 0, 77, "R7 zero lines");

    // R8: outputs hold after the pulse
    held = seg_len;
    repeat (6) @(negedge clk);
    check(seg_len == held && !done, "R8 hold", $sformatf("%0d", seg_len), $sformatf("%0d", held));

    // R9: start during a division is ignored
    @(negedge clk);
    drive(86100, 32, 30, 512, "R9 busy poke");
    repeat (3) @(negedge clk);
    blank_cnt = 17'd7; sub_cnt = 7'd1; line_cnt = 7'd1; base_len = 10'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();
    repeat (50) @(negedge clk);
    check(exp_q.size() == 0, "R9 no extra result", "pending", "empty");

    // R9: start in the same cycle as done is accepted
    @(negedge clk);
    drive(50000, 10, 10, 200, "R9 first of pair");
    while (!done) @(negedge clk);
    drive(3000, 4, 6, 20, "R9 back to back");
    drain();
    repeat (50) @(negedge clk);
    check(exp_q.size() == 0, "R9 pair drained", $sformatf("%0d", exp_q.size()), "0");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule